// File: doc/BRIEF.md
# Serial Two-Wire Register Target

This block is the target side of an I2C link in front of a small bank of 8-bit registers. A fast system clock oversamples the SCL and SDA lines. Each line goes through a synchronizer and a short glitch filter, and then the block finds bus edges, START and STOP conditions.

A write transaction carries the device address byte, a register pointer byte and then any number of data bytes. Each data byte becomes a one-cycle write strobe toward the bank, and the pointer then advances. A read transaction returns bank bytes, starting either from a pointer that was just set (write, then repeated START, then read) or from the address after the last one touched.

The pointer wraps at a configurable last address. The block drives SDA only through an open-drain enable. An active-low reset pin clears the block and hides the bus from it.

Top module: `i2c_reg_target`

## Requirements
- R1: A START (SDA falling while SCL is high), including a repeated START in the middle of a transfer, always restarts the address phase. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The device address is 0001001b. Address bytes 12h (write) and 13h (read) are acknowledged by pulling SDA low on the ninth clock. Any other address byte is not acknowledged, and the bus is then ignored until the next START: no acknowledge and no write strobe.
- R3: SDA is driven or released only while SCL is low. Read data leaves MSB first.
- R4: In a write, the byte after the address sets the pointer. The first data byte is written at the pointer and each later data byte one address higher. Every data byte raises `regWe` for exactly one cycle, with its address and data, while SCL is low.
- R5: The pointer advances from the last address (07h) to 00h, on writes and on reads alike.
- R6: A read with no pointer phase starts at the address after the last one written or read. After reset, that address is 00h.
- R7: A pointer write followed by a repeated START and a read address returns data from the pointer onward, incrementing per byte.
- R8: When the controller does not acknowledge a read byte, the block releases SDA and sends nothing more until a START.
- R9: While `rstN` is low, both bus lines are seen as high: nothing is acknowledged, nothing is written, and the pointer returns to 00h.
- R10: A pulse on SCL lasting fewer than three system clocks is filtered out and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Active-low reset; also masks the bus inputs |
| sclIn | input | 1 | SCL line as seen at the pad |
| sdaIn | input | 1 | SDA line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regWe | output | 1 | One-cycle register write strobe |
| regWaddr | output | 8 | Register address for the write strobe |
| regWdata | output | 8 | Register data for the write strobe |
| regRaddr | output | 8 | Register address being read (current pointer) |
| regRdata | input | 8 | Read data returned by the bank for `regRaddr` |

## Verification
The bench drives the pointer across 07h on writes and on reads. A design without the wrap would write or read address 08h. The bench also reads with no pointer phase right after reset, after reads and after a wrapped write. A design that keeps the last address, rather than the next one, returns the previous byte. Other cases send a wrong address byte, a repeated START after a bare pointer byte, a two-clock SCL spike in the middle of a write, and a reset pulse in the middle of a transfer. A faulty design would acknowledge a foreign address, write at the stale pointer, shift in an extra bit and so corrupt the data byte, or resume at a pointer that the reset should have cleared.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } tgtState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrBits;
    logic loadPtr;
    logic storeData;
    logic loadTx;
    logic shiftTx;
  } dpCmd_t;

endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclFilt,
  output logic sdaFilt,
  output logic sclRise,
  output logic sclFall,
  output logic startC,
  output logic stopC
);
  // bit 0 = SCL, bit 1 = SDA
  logic [1:0] lineIn, lineFilt, linePrev;

  assign lineIn = rstN ? {sdaRaw, sclRaw} : 2'b11;

  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [SYNC_STAGES-1:0] syncQ;
    logic [FILT_LEN-1:0]    histQ;
    logic                   filtQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        histQ <= '1;
        filtQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn[g]};
        histQ <= {histQ[FILT_LEN-2:0], syncQ[SYNC_STAGES-1]};
        if (&histQ)       filtQ <= 1'b1;
        else if (~|histQ) filtQ <= 1'b0;
      end
    end
    assign lineFilt[g] = filtQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= 2'b11;
    else       linePrev <= lineFilt;
  end

  assign sclFilt = lineFilt[0];
  assign sdaFilt = lineFilt[1];
  assign sclRise = lineFilt[0] & ~linePrev[0];
  assign sclFall = ~lineFilt[0] & linePrev[0];
  assign startC  = lineFilt[0] & linePrev[0] & linePrev[1] & ~lineFilt[1];
  assign stopC   = lineFilt[0] & linePrev[0] & ~linePrev[1] & lineFilt[1];
endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath import i2c_tgt_pkg::*; #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] PTR_LAST = 'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              sclRise,
  input  logic              sdaFilt,
  input  logic [DATA_W-1:0] regRdata,
  output logic              byteFull,
  output logic [DATA_W-1:0] rxByte,
  output logic              txMsb,
  output logic              regWe,
  output logic [DATA_W-1:0] regWaddr,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRaddr
);
  localparam int              BIT_W   = $clog2(DATA_W + 2);
  localparam logic [BIT_W-1:0] CNT_FULL = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] CNT_TOP  = BIT_W'(DATA_W + 1);

  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] rxShift, txShift, ptr, ptrNext;

  assign ptrNext  = (ptr == PTR_LAST) ? '0 : ptr + DATA_W'(1);
  assign byteFull = (bitCnt == CNT_FULL);
  assign rxByte   = rxShift;
  assign txMsb    = txShift[DATA_W-1];
  assign regRaddr = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '1;
      ptr      <= '0;
      regWe    <= 1'b0;
      regWaddr <= '0;
      regWdata <= '0;
    end else begin
      if (cmd.clrBits)                      bitCnt <= '0;
      else if (sclRise && bitCnt != CNT_TOP) bitCnt <= bitCnt + BIT_W'(1);

      if (sclRise) rxShift <= {rxShift[DATA_W-2:0], sdaFilt};

      if (cmd.loadTx)       txShift <= regRdata;
      else if (cmd.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};

      if (cmd.loadPtr)                        ptr <= rxShift;
      else if (cmd.storeData || cmd.loadTx)   ptr <= ptrNext;

      regWe <= cmd.storeData;
      if (cmd.storeData) begin
        regWaddr <= ptr;
        regWdata <= rxShift;
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl import i2c_tgt_pkg::*; #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startC,
  input  logic              stopC,
  input  logic              sdaFilt,
  input  logic              byteFull,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txMsb,
  output dpCmd_t            cmd,
  output logic              sdaOe
);
  tgtState_t st, stNext;
  logic      rdMode, rdNext, mAck, mAckNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      rdMode <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      st     <= stNext;
      rdMode <= rdNext;
      mAck   <= mAckNext;
    end
  end

  always_comb begin
    stNext   = st;
    rdNext   = rdMode;
    mAckNext = mAck;
    cmd      = '0;
    if (startC) begin
      stNext      = ST_ADDR;
      cmd.clrBits = 1'b1;
    end else if (stopC) begin
      stNext = ST_IDLE;
    end else begin
      case (st)
        ST_ADDR: if (sclFall && byteFull) begin
          if (rxByte[DATA_W-1:1] == DEV_ADDR) begin
            stNext = ST_AACK;
            rdNext = rxByte[0];
          end else begin
            stNext = ST_SKIP;
          end
        end
        ST_AACK: if (sclFall) begin
          cmd.clrBits = 1'b1;
          if (rdMode) begin
            cmd.loadTx = 1'b1;
            stNext     = ST_RDAT;
          end else begin
            stNext = ST_PTR;
          end
        end
        ST_PTR: if (sclFall && byteFull) begin
          cmd.loadPtr = 1'b1;
          stNext      = ST_PACK;
        end
        ST_PACK, ST_WACK: if (sclFall) begin
          cmd.clrBits = 1'b1;
          stNext      = ST_WDAT;
        end
        ST_WDAT: if (sclFall && byteFull) begin
          cmd.storeData = 1'b1;
          stNext        = ST_WACK;
        end
        ST_RDAT: if (sclFall) begin
          if (byteFull) stNext = ST_RACK;
          else          cmd.shiftTx = 1'b1;
        end
        ST_RACK: begin
          if (sclRise) mAckNext = ~sdaFilt;
          if (sclFall) begin
            if (mAck) begin
              cmd.clrBits = 1'b1;
              cmd.loadTx  = 1'b1;
              stNext      = ST_RDAT;
            end else begin
              stNext = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (st == ST_AACK) || (st == ST_PACK) || (st == ST_WACK) ||
                 ((st == ST_RDAT) && !txMsb);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target import i2c_tgt_pkg::*; #(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR    = 'h09,
  parameter logic [DATA_W-1:0] PTR_LAST    = 'h07,
  parameter int                SYNC_STAGES = 2,
  parameter int                FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              regWe,
  output logic [DATA_W-1:0] regWaddr,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRaddr,
  input  logic [DATA_W-1:0] regRdata
);
  logic              sclFilt, sdaFilt, sclRise, sclFall, startC, stopC;
  logic              byteFull, txMsb;
  logic [DATA_W-1:0] rxByte;
  dpCmd_t            cmd;

  i2c_tgt_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) uFilt (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sclFilt(sclFilt), .sdaFilt(sdaFilt), .sclRise(sclRise),
    .sclFall(sclFall), .startC(startC), .stopC(stopC)
  );

  i2c_tgt_ctrl #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startC(startC), .stopC(stopC), .sdaFilt(sdaFilt), .byteFull(byteFull),
    .rxByte(rxByte), .txMsb(txMsb), .cmd(cmd), .sdaOe(sdaOe)
  );

  i2c_tgt_datapath #(.DATA_W(DATA_W), .PTR_LAST(PTR_LAST)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sclRise(sclRise), .sdaFilt(sdaFilt),
    .regRdata(regRdata), .byteFull(byteFull), .rxByte(rxByte), .txMsb(txMsb),
    .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata), .regRaddr(regRaddr)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rstN,
  input logic sclFilt,
  input logic startC,
  input logic sdaOe,
  input logic regWe
);
  // R1: a START leaves the target not driving in the address phase
  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rstN)
    startC |=> !sdaOe);

  // R3: the SDA drive never changes while the filtered SCL stays high
  a_r3_oe_stable_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclFilt && $past(sclFilt)) |-> $stable(sdaOe));

  // R4: the write strobe is a single-cycle pulse
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R4: the write strobe falls in the SCL low phase after the eighth bit
  a_r4_we_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !sclFilt);
endmodule

bind i2c_reg_target i2c_reg_target_chk uChk (
  .clk(clk), .rstN(rstN), .sclFilt(sclFilt), .startC(startC),
  .sdaOe(sdaOe), .regWe(regWe)
);

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int H = 10;
  localparam int WATCHDOG = 150000;
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h033C, 16'h07FF,
                                      16'h0500, 16'h0181, 16'h065A};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rstN, sclM, sdaM, sdaBus, preload;
  logic       sdaOe, regWe;
  logic [7:0] regWaddr, regWdata, regRaddr, regRdata;
  logic [7:0] bank [8];
  logic [7:0] model [8];
  int         weCount, total, bad, nextAddr;
  bit         done;

  assign sdaBus   = sdaM & ~sdaOe;
  assign regRdata = bank[regRaddr[2:0]];

  i2c_reg_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata),
    .regRaddr(regRaddr), .regRdata(regRdata)
  );

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < 8; i++) bank[i] <= 8'h10 + 8'(i);
      weCount <= 0;
    end else if (regWe) begin
      bank[regWaddr[2:0]] <= regWdata;
      weCount <= weCount + 1;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(Q);
      sclM = 1'b1; waitClk(H);
      sclM = 1'b0; waitClk(Q);
    end
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    ack = sdaBus; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitClk(Q);
      sclM = 1'b1; waitClk(Q);
      b[i] = sdaBus; waitClk(Q);
      sclM = 1'b0; waitClk(Q);
    end
    sdaM = ackIt ? 1'b0 : 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0; waitClk(Q);
    sdaM = 1'b1;
  endtask

  function automatic int wrapNext(input int a);
    return (a == 7) ? 0 : a + 1;
  endfunction

  task automatic writeRegs(input logic [7:0] p, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic a;
    logic [7:0] b;
    int idx;
    busStart;
    sendByte(8'h12, a); chk("R2 write address ack", 8'(a), 8'h00);
    sendByte(p, a);     chk("R4 pointer ack", 8'(a), 8'h00);
    idx = int'(p[2:0]);
    for (int k = 0; k < n; k++) begin
      b = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      sendByte(b, a); chk("R4 data ack", 8'(a), 8'h00);
      model[idx] = b;
      idx = wrapNext(idx);
    end
    busStop;
    nextAddr = idx;
  endtask

  task automatic readRegs(input logic usePtr, input logic [7:0] p, input int n, input string tag);
    logic a;
    logic [7:0] b;
    busStart;
    if (usePtr) begin
      sendByte(8'h12, a); chk("R7 address ack", 8'(a), 8'h00);
      sendByte(p, a);     chk("R7 pointer ack", 8'(a), 8'h00);
      busStart;
      nextAddr = int'(p[2:0]);
    end
    sendByte(8'h13, a); chk("R2 read address ack", 8'(a), 8'h00);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      chk(tag, b, model[nextAddr]);
      nextAddr = wrapNext(nextAddr);
    end
    waitClk(Q);
    chk("R8 SDA released after NACK", 8'(sdaOe), 8'h00);
    busStop;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL all watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wBefore;
    logic a;
    total = 0; bad = 0; done = 1'b0;
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1; preload = 1'b1;
    for (int i = 0; i < 8; i++) model[i] = 8'h10 + 8'(i);
    nextAddr = 0;
    waitClk(4);
    preload = 1'b0;
    chk("R9 reset sdaOe", 8'(sdaOe), 8'h00);
    chk("R9 reset regWe", 8'(regWe), 8'h00);
    chk("R9 reset pointer", regRaddr, 8'h00);
    rstN = 1'b1;
    waitClk(H);

    // R6: read without pointer from reset, then resume
    readRegs(1'b0, 8'h00, 2, "R6 read from reset pointer");
    readRegs(1'b0, 8'h00, 1, "R6 resume after last read");

    // table walk: single writes then combined reads (R4, R7, R3 MSB first)
    for (int k = 0; k < 6; k++) begin
      writeRegs(VEC[k][15:8], 1, VEC[k][7:0], 8'h00, 8'h00);
      chk("R4 bank contents", bank[VEC[k][10:8]], model[VEC[k][10:8]]);
      readRegs(1'b1, VEC[k][15:8], 1, "R7 combined read value");
    end

    // R5: write burst across the wrap
    wBefore = weCount;
    writeRegs(8'h06, 3, 8'hA1, 8'hB2, 8'hC3);
    chk("R5 wrap write at 06", bank[6], 8'hA1);
    chk("R5 wrap write at 07", bank[7], 8'hB2);
    chk("R5 wrap write at 00", bank[0], 8'hC3);
    chk("R4 one strobe per byte", 8'(weCount - wBefore), 8'd3);
    readRegs(1'b0, 8'h00, 1, "R6 resume after wrapped write");

    // R5: read burst across the wrap
    readRegs(1'b1, 8'h07, 2, "R5 read wrap");

    // R2: foreign addresses
    wBefore = weCount;
    busStart;
    sendByte(8'h20, a); chk("R2 foreign address nack", 8'(a), 8'h01);
    sendByte(8'h77, a); chk("R2 ignored until START", 8'(a), 8'h01);
    busStop;
    busStart;
    sendByte(8'h14, a); chk("R2 neighbour address nack", 8'(a), 8'h01);
    busStop;
    chk("R2 no write strobe", 8'(weCount - wBefore), 8'd0);

    // R1: repeated START after a bare pointer byte restarts the address phase
    busStart;
    sendByte(8'h12, a); sendByte(8'h02, a);
    busStart;
    sendByte(8'h12, a); chk("R1 address after restart", 8'(a), 8'h00);
    sendByte(8'h05, a); sendByte(8'h9E, a);
    busStop;
    model[5] = 8'h9E; nextAddr = 6;
    chk("R1 write after restart", bank[5], 8'h9E);
    chk("R1 pointer-only left bank", bank[2], model[2]);
    chk("R1 released after STOP", 8'(sdaOe), 8'h00);

    // R10: short SCL spike during a write
    busStart;
    sendByte(8'h12, a); sendByte(8'h04, a);
    sclM = 1'b1; waitClk(2); sclM = 1'b0; waitClk(3);
    sendByte(8'h6B, a); chk("R10 ack after spike", 8'(a), 8'h00);
    busStop;
    model[4] = 8'h6B; nextAddr = 5;
    chk("R10 data intact after spike", bank[4], 8'h6B);

    // R9: reset in the middle of a transfer
    wBefore = weCount;
    busStart;
    sendByte(8'h12, a);
    rstN = 1'b0; waitClk(2);
    chk("R9 no drive in reset", 8'(sdaOe), 8'h00);
    sendByte(8'h03, a); chk("R9 no ack in reset", 8'(a), 8'h01);
    sendByte(8'h44, a);
    rstN = 1'b1; waitClk(Q);
    busStop;
    chk("R9 no write through reset", 8'(weCount - wBefore), 8'd0);
    nextAddr = 0;
    readRegs(1'b0, 8'h00, 1, "R9 pointer cleared by reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule